// File: doc/BRIEF.md
# Segment Address Translator with Protection Checks

This block turns a segmented virtual reference into a real memory address. A reference names a segment number, a displacement inside that segment and the kind of access wanted. The block works out where the segment's descriptor sits in memory by adding the segment number to a table base register. It fetches that descriptor over a simple request/response read port and then checks three things: that the segment is resident, that the displacement lies within the segment's length, and that the requested access is permitted.

If every check passes, the block returns the segment base plus the displacement. If any check fails, it returns exactly one fault status and no address. It handles one reference at a time. While a translation is in flight the block reports busy and drops new requests. A fault status is meant to be handed to the operating system, which may bring the segment in and then retry the reference.

Top module: `seg_xlate`

## Requirements
- R1: The descriptor read address is `tbl_base + xl_seg`, computed modulo 2^ADDR_W. It is presented on `mem_rd_addr` together with a single-cycle `mem_rd_req` pulse, in the cycle after the reference is accepted.
- R2: The descriptor layout, from LSB upward, is: bit 0 resident, bit 1 read-allowed, bit 2 write-allowed, bit 3 execute-allowed, bit 4 append-allowed, then LEN_W bits of length, then ADDR_W bits of segment base.
- R3: A descriptor whose resident bit is 0 yields status 01 (missing).
- R4: A displacement strictly greater than the length field yields status 10 (overflow). A displacement equal to the length is in range.
- R5: The operation code is 00 read, 01 write, 10 execute, 11 append. If the permission bit for the requested operation is 0, the status is 11 (protection).
- R6: When several faults apply, only one status is reported. Missing wins over overflow, and overflow wins over protection.
- R7: An access that passes every check returns status 00 with `res_addr = base + displacement`, computed modulo 2^ADDR_W (an addition, not a concatenation).
- R8: `res_valid` is a one-cycle pulse, raised exactly one cycle after the cycle in which `mem_rd_vld` returns the descriptor. On any fault status, `res_addr` is 0.
- R9: While `xl_busy` is high, `xl_valid` is ignored. No further descriptor read is issued, and the result in flight is unaffected.
- R10: After reset, `xl_busy`, `mem_rd_req` and `res_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | ADDR_W | Segment descriptor table base |
| xl_valid | input | 1 | Reference request |
| xl_seg | input | SEG_W | Segment number |
| xl_disp | input | LEN_W | Displacement within segment |
| xl_op | input | 2 | Operation code |
| xl_busy | output | 1 | Translation in flight |
| mem_rd_req | output | 1 | Descriptor read request pulse |
| mem_rd_addr | output | ADDR_W | Descriptor read address |
| mem_rd_vld | input | 1 | Descriptor data valid |
| mem_rd_data | input | ENTRY_W | Descriptor contents |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | 00 ok, 01 missing, 10 overflow, 11 protection |
| res_addr | output | ADDR_W | Real address (0 on fault) |

## Verification
The assertions assume that the memory raises `mem_rd_vld` only in answer to a pending read, at least one cycle after the request and only once per request. The bench's memory model keeps to this by answering each observed request exactly once, after a chosen latency of one or more cycles. They also assume that `tbl_base` stays stable while a translation is in flight. The bench changes it only between references, including near the top of the address space so that the wrap case is exercised.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    parameter int ADDR_W  = 16;
    parameter int SEG_W   = 4;
    parameter int LEN_W   = 12;
    localparam int PERM_W  = 4;
    localparam int ENTRY_W = ADDR_W + LEN_W + PERM_W + 1;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_EXEC   = 2'b10,
        OP_APPEND = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'b00,
        ST_MISSING  = 2'b01,
        ST_OVERFLOW = 2'b10,
        ST_PROTECT  = 2'b11
    } status_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'b00,
        FS_REQ  = 2'b01,
        FS_WAIT = 2'b10
    } fetch_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic              allow_append;
        logic              allow_exec;
        logic              allow_write;
        logic              allow_read;
        logic              resident;
    } seg_desc_t;

    function automatic logic op_permitted(seg_desc_t d, op_e op);
        case (op)
            OP_READ:   return d.allow_read;
            OP_WRITE:  return d.allow_write;
            OP_EXEC:   return d.allow_exec;
            default:   return d.allow_append;
        endcase
    endfunction
endpackage

// File: rtl/seg_fetch_ctl.sv
module seg_fetch_ctl
    import seg_xlate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rd_vld,
    output logic busy,
    output logic rd_req,
    output logic capture
);
    fetch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            FS_IDLE: if (start)  state_d = FS_REQ;
            FS_REQ:              state_d = FS_WAIT;
            FS_WAIT: if (rd_vld) state_d = FS_IDLE;
            default:             state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FS_IDLE;
        else     state_q <= state_d;
    end

    assign busy    = (state_q != FS_IDLE);
    assign rd_req  = (state_q == FS_REQ);
    assign capture = (state_q == FS_WAIT) && rd_vld;

    // R1: read request is a single-cycle pulse
    a_r1_req_single: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);
    // R1: request follows acceptance of a reference
    a_r1_req_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> rd_req);
    // R9: no new request while one is already in flight
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_req) |=> !rd_req);
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [LEN_W-1:0]  disp,
    input  op_e               op,
    output status_e           status,
    output logic [ADDR_W-1:0] real_addr
);
    logic [ADDR_W-1:0] disp_ext;
    assign disp_ext = ADDR_W'(disp);

    always_comb begin
        if (!desc.resident)           status = ST_MISSING;
        else if (disp > desc.len)     status = ST_OVERFLOW;
        else if (!op_permitted(desc, op)) status = ST_PROTECT;
        else                          status = ST_OK;
    end

    assign real_addr = (status == ST_OK) ? (desc.base + disp_ext) : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SEG_W,
    parameter int LW = LEN_W,
    localparam int EW = ENTRY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] tbl_base,
    input  logic          xl_valid,
    input  logic [SW-1:0] xl_seg,
    input  logic [LW-1:0] xl_disp,
    input  logic [1:0]    xl_op,
    output logic          xl_busy,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_vld,
    input  logic [EW-1:0] mem_rd_data,
    output logic          res_valid,
    output logic [1:0]    res_status,
    output logic [AW-1:0] res_addr
);
    logic              start, capture, busy;
    logic [AW-1:0]     rd_addr_q;
    logic [LW-1:0]     disp_q;
    op_e               op_q;
    status_e           chk_status;
    logic [AW-1:0]     chk_addr;
    seg_desc_t         desc;

    assign start = xl_valid && !busy;
    assign desc  = seg_desc_t'(mem_rd_data);

    seg_fetch_ctl u_fetch (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_vld  (mem_rd_vld),
        .busy    (busy),
        .rd_req  (mem_rd_req),
        .capture (capture)
    );

    seg_check u_check (
        .desc      (desc),
        .disp      (disp_q),
        .op        (op_q),
        .status    (chk_status),
        .real_addr (chk_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr_q <= '0;
            disp_q    <= '0;
            op_q      <= OP_READ;
        end else if (start) begin
            rd_addr_q <= tbl_base + AW'(xl_seg);
            disp_q    <= xl_disp;
            op_q      <= op_e'(xl_op);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_status <= ST_OK;
            res_addr   <= '0;
        end else begin
            res_valid <= capture;
            if (capture) begin
                res_status <= chk_status;
                res_addr   <= chk_addr;
            end
        end
    end

    assign xl_busy     = busy;
    assign mem_rd_addr = rd_addr_q;

    // R8: result follows returned data by exactly one cycle
    a_r8_result_after_data: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(mem_rd_vld) && $past(busy));
    // R8: a faulted result carries no address
    a_r8_fault_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status != 2'b00) |-> res_addr == '0);
    // R8: result is a single-cycle pulse
    a_r8_result_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    // R9: read address held while a translation is in flight
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_rd_addr));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    import seg_xlate_pkg::*;

    logic                clk = 0;
    logic                rst = 1;
    logic [ADDR_W-1:0]   tbl_base = '0;
    logic                xl_valid = 0;
    logic [SEG_W-1:0]    xl_seg = '0;
    logic [LEN_W-1:0]    xl_disp = '0;
    logic [1:0]          xl_op = '0;
    logic                xl_busy, mem_rd_req, res_valid;
    logic [ADDR_W-1:0]   mem_rd_addr, res_addr;
    logic                mem_rd_vld = 0;
    logic [ENTRY_W-1:0]  mem_rd_data = '0;
    logic [1:0]          res_status;

    int checks = 0, errors = 0, cyc = 0, vld_cyc = -10, req_cnt = 0, lat = 1;
    logic [ADDR_W-1:0] last_req_addr;
    logic [ENTRY_W-1:0] tbl_mem [0:15];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seg_xlate u_dut (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .xl_valid(xl_valid),
        .xl_seg(xl_seg), .xl_disp(xl_disp), .xl_op(xl_op), .xl_busy(xl_busy),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_vld(mem_rd_vld),
        .mem_rd_data(mem_rd_data), .res_valid(res_valid), .res_status(res_status),
        .res_addr(res_addr)
    );

    // R2 layout: resident bit0, perms bits1..4 (r,w,x,a), len, base
    function automatic logic [ENTRY_W-1:0] mk(input logic res, input logic [ADDR_W-1:0] base,
                                             input logic [LEN_W-1:0] len, input logic [3:0] axwr);
        return {base, len, axwr, res};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory responder
    initial forever begin
        @(negedge clk);
        if (mem_rd_req === 1'b1) begin
            req_cnt++;
            last_req_addr = mem_rd_addr;
            repeat (lat) @(negedge clk);
            mem_rd_data = tbl_mem[4'(last_req_addr - tbl_base)];
            mem_rd_vld  = 1;
            vld_cyc     = cyc;
            @(negedge clk);
            mem_rd_vld  = 0;
        end
    end

    task automatic xlate(input string req, input logic [SEG_W-1:0] seg,
                         input logic [LEN_W-1:0] disp, input logic [1:0] op,
                         input logic [1:0] exp_st, input logic [ADDR_W-1:0] exp_addr);
        int t;
        int rc0;
        rc0 = req_cnt;
        @(negedge clk);
        xl_valid = 1; xl_seg = seg; xl_disp = disp; xl_op = op;
        @(negedge clk);
        xl_valid = 0;
        t = 0;
        while (res_valid !== 1'b1 && t < 100) begin @(negedge clk); t++; end
        chk({req, " R8 result seen"}, 32'(res_valid), 1);
        chk({req, " R8 latency"}, 32'(cyc), 32'(vld_cyc + 1));
        chk({req, " R1 table address"}, 32'(last_req_addr), 32'(ADDR_W'(tbl_base + ADDR_W'(seg))));
        chk({req, " R1 single request"}, 32'(req_cnt - rc0), 1);
        chk({req, " status"}, 32'(res_status), 32'(exp_st));
        chk({req, " address"}, 32'(res_addr), 32'(exp_addr));
        @(negedge clk);
        chk({req, " R8 pulse"}, 32'(res_valid), 0);
    endtask

    task automatic t_reset;
        chk("R10 busy", 32'(xl_busy), 0);
        chk("R10 req", 32'(mem_rd_req), 0);
        chk("R10 valid", 32'(res_valid), 0);
    endtask

    task automatic t_ok;
        tbl_base = 16'h0200;
        lat = 1; xlate("R7 read ok", 4'd0, 12'h010, 2'b00, 2'b00, 16'h1010);
        lat = 3; xlate("R4 disp equals len", 4'd0, 12'h0FF, 2'b00, 2'b00, 16'h10FF);
        lat = 2; xlate("R4 overflow", 4'd0, 12'h100, 2'b00, 2'b10, 16'h0);
        xlate("R7 append all perms", 4'd1, 12'h004, 2'b11, 2'b00, 16'h2004);
        xlate("R7 addition not concat", 4'd5, 12'h020, 2'b01, 2'b00, 16'h0010);
    endtask

    task automatic t_faults;
        xlate("R3 missing", 4'd2, 12'h000, 2'b00, 2'b01, 16'h0);
        xlate("R5 write denied", 4'd3, 12'h001, 2'b01, 2'b11, 16'h0);
        xlate("R5 exec denied", 4'd3, 12'h001, 2'b10, 2'b11, 16'h0);
        xlate("R5 append denied", 4'd3, 12'h001, 2'b11, 2'b11, 16'h0);
        xlate("R5 exec only ok", 4'd4, 12'h002, 2'b10, 2'b00, 16'h4002);
        xlate("R5 exec only read denied", 4'd4, 12'h002, 2'b00, 2'b11, 16'h0);
        xlate("R6 missing wins", 4'd2, 12'hFFF, 2'b01, 2'b01, 16'h0);
        xlate("R6 overflow wins", 4'd3, 12'h800, 2'b01, 2'b10, 16'h0);
    endtask

    task automatic t_wrap;
        tbl_base = 16'hFFFE;
        xlate("R1 table wrap", 4'd3, 12'h008, 2'b00, 2'b00, 16'h3008);
        tbl_base = 16'h0200;
    endtask

    task automatic t_busy;
        int rc0, t;
        rc0 = req_cnt;
        lat = 4;
        @(negedge clk);
        xl_valid = 1; xl_seg = 4'd0; xl_disp = 12'h020; xl_op = 2'b00;
        @(negedge clk);
        xl_seg = 4'd2; xl_op = 2'b01;
        @(negedge clk);
        chk("R9 busy high", 32'(xl_busy), 1);
        @(negedge clk);
        xl_valid = 0;
        t = 0;
        while (res_valid !== 1'b1 && t < 100) begin @(negedge clk); t++; end
        chk("R9 first result status", 32'(res_status), 0);
        chk("R9 first result addr", 32'(res_addr), 32'h1020);
        repeat (8) @(negedge clk);
        chk("R9 one request only", 32'(req_cnt - rc0), 1);
        chk("R9 no extra result", 32'(res_valid), 0);
        lat = 1;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tbl_mem[i] = '0;
        tbl_mem[0] = mk(1, 16'h1000, 12'h0FF, 4'b0001);
        tbl_mem[1] = mk(1, 16'h2000, 12'h0FF, 4'b1111);
        tbl_mem[2] = mk(0, 16'h3000, 12'h000, 4'b0000);
        tbl_mem[3] = mk(1, 16'h3000, 12'h010, 4'b0001);
        tbl_mem[4] = mk(1, 16'h4000, 12'h010, 4'b0100);
        tbl_mem[5] = mk(1, 16'hFFF0, 12'h0FF, 4'b0011);
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ok();
        t_faults();
        t_wrap();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule